// File: doc/BRIEF.md
# Task-Driven Block Cipher Job Controller

This block runs one block-cipher job at a time on behalf of software. A one-cycle start strobe arms a countdown of programmable length. When the countdown expires, the block reads a 48-byte job record from memory through a simple word port. The record holds a 16-byte key at offset 0, a 16-byte input block at offset 16, and a 16-byte result area at offset 32. The key and input block go to an external cipher port, and the cipher's answer is written back into the result area. A stop strobe that arrives during the countdown aborts the job and reports an error event. A record pointer of zero at expiry is refused and flagged as a fault.

Software programs the block through a small register port. That port holds the record pointer, the latency value, a register that restores the default latency, write-one-to-set and write-one-to-clear interrupt enable registers, and one register each for the done and error events. A level interrupt is raised while any event is pending and enabled.

The sequencer has three states:
- SEQ_IDLE goes to SEQ_COUNT on start.
- SEQ_COUNT goes to SEQ_IDLE on stop (abort) or on expiry with a zero pointer (fault). It goes to SEQ_MOVE on expiry with a valid pointer. It stays in SEQ_COUNT on a fresh start, which reloads the countdown.
- SEQ_MOVE goes to SEQ_IDLE when the mover finishes.

The mover has four states:
- MV_IDLE goes to MV_READ on its go pulse.
- MV_READ goes to MV_CIPHER after the eighth read word is captured.
- MV_CIPHER goes to MV_WRITE after one cycle.
- MV_WRITE goes to MV_IDLE after the fourth write.

Top module: `cipher_job_ctrl`

## Requirements
- R1: A start strobe seen while idle makes `busy` high from the next cycle for exactly L cycles, where L is the latency register value.
- R2: A stop strobe while `busy` is high drops `busy` on the next cycle, sets the error event, and produces no memory access for that job. When start and stop arrive together, stop wins.
- R3: A stop strobe while `busy` is low changes no state: the error event, `busy` and `irq` stay as they were.
- R4: A start strobe while `busy` is high restarts the countdown, so `busy` stays high for L cycles counted from that strobe.
- R5: On expiry with a nonzero pointer P, the block reads eight words from P, P+4, up to P+28. The first four words form the key and the next four form the input block, big-endian: the word at the lowest address lands in bits 127:96. The block then writes the four result words to P+32 through P+44 in the same order, and sets the done event after the last write.
- R6: On expiry with a zero pointer, `ptr_fault` pulses for one cycle, no memory access occurs, and the done event stays clear.
- R7: `irq` is high exactly while (done event AND enable bit 0) OR (error event AND enable bit 1).
- R8: Writing to offset 0x0C sets the enable bits where the write data is 1. Writing to offset 0x10 clears them where the write data is 1. Both offsets read back the enables. No other access changes the enables.
- R9: A write to the done event register (0x14) or the error event register (0x18) loads bit 0 of the write data. Writing 0 clears the event, so `irq` drops in the cycle after the write. A hardware set in the same cycle wins over the write.
- R10: The latency register (0x04) takes a new value at run time. Any write to 0x08 restores the default value. A latency of 0 behaves as 1.
- R11: Reset clears the pointer (0x00), events and enables, restores the default latency, and cancels any pending countdown, leaving `busy` low.
- R12: Start and stop strobes arriving while the record is being moved are ignored: the job finishes normally, with no error event and no new countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_start | input | 1 | Start strobe, one cycle |
| task_stop | input | 1 | Stop strobe, one cycle |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after a read request |
| cph_go | output | 1 | Cipher operands valid, result sampled this cycle |
| cph_key | output | BLK_W | Cipher key |
| cph_din | output | BLK_W | Cipher input block |
| cph_result | input | BLK_W | Cipher output block |
| busy | output | 1 | Countdown in progress |
| ptr_fault | output | 1 | One-cycle pulse on expiry with a zero pointer |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check, on every cycle, several local rules:
- A rising `busy` always follows a start strobe.
- A stop while busy leaves the unit idle with the error event set.
- A stop while idle never raises the error event.
- No memory traffic happens during the countdown or on a fault.
- The enables move only when their set or clear registers are written.
- A pending interrupt always has an event behind it.

Only the bench's scenarios can show the rest. These are the exact countdown length, including restart and a latency of zero, and the addresses and big-endian word order of the read and write traffic, compared against results the bench computes itself. They also cover the effect of restoring the default latency, the ignoring of strobes during the record move, and recovery from a reset in the middle of a countdown.

// File: rtl/cjc_pkg.sv
package cjc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_COUNT,
        SEQ_MOVE
    } seq_state_t;

    typedef enum logic [1:0] {
        MV_IDLE,
        MV_READ,
        MV_CIPHER,
        MV_WRITE
    } mv_state_t;

    // register byte offsets
    localparam logic [7:0] OFS_PTR    = 8'h00;
    localparam logic [7:0] OFS_LAT    = 8'h04;
    localparam logic [7:0] OFS_LATDEF = 8'h08;
    localparam logic [7:0] OFS_ENSET  = 8'h0C;
    localparam logic [7:0] OFS_ENCLR  = 8'h10;
    localparam logic [7:0] OFS_EVDONE = 8'h14;
    localparam logic [7:0] OFS_EVERR  = 8'h18;

    // enable bit positions
    localparam int EN_DONE_BIT = 0;
    localparam int EN_ERR_BIT  = 1;

endpackage

// File: rtl/cjc_regfile.sv
module cjc_regfile
    import cjc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LAT_W       = 16,
    parameter int LAT_DEFAULT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              set_done,
    input  logic              set_err,
    output logic [ADDR_W-1:0] data_ptr,
    output logic [LAT_W-1:0]  latency,
    output logic [1:0]        int_en,
    output logic              ev_done,
    output logic              ev_err,
    output logic              irq
);

    localparam logic [LAT_W-1:0] LAT_RST = LAT_W'(LAT_DEFAULT);

    logic wr_ptr, wr_lat, wr_latdef, wr_enset, wr_enclr, wr_evdone, wr_everr;

    always_comb begin
        wr_ptr    = reg_we && (reg_addr == OFS_PTR);
        wr_lat    = reg_we && (reg_addr == OFS_LAT);
        wr_latdef = reg_we && (reg_addr == OFS_LATDEF);
        wr_enset  = reg_we && (reg_addr == OFS_ENSET);
        wr_enclr  = reg_we && (reg_addr == OFS_ENCLR);
        wr_evdone = reg_we && (reg_addr == OFS_EVDONE);
        wr_everr  = reg_we && (reg_addr == OFS_EVERR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_ptr <= '0;
            latency  <= LAT_RST;
        end else begin
            if (wr_ptr)
                data_ptr <= reg_wdata[ADDR_W-1:0];
            if (wr_latdef)
                latency <= LAT_RST;
            else if (wr_lat)
                latency <= reg_wdata[LAT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_en <= 2'b00;
        end else if (wr_enset) begin
            int_en <= int_en | reg_wdata[1:0];
        end else if (wr_enclr) begin
            int_en <= int_en & ~reg_wdata[1:0];
        end
    end

    // hardware set has priority over a software write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_done <= 1'b0;
            ev_err  <= 1'b0;
        end else begin
            if (set_done)
                ev_done <= 1'b1;
            else if (wr_evdone)
                ev_done <= reg_wdata[0];
            if (set_err)
                ev_err <= 1'b1;
            else if (wr_everr)
                ev_err <= reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_PTR:              reg_rdata = 32'(data_ptr);
            OFS_LAT:              reg_rdata = 32'(latency);
            OFS_LATDEF:           reg_rdata = 32'(LAT_RST);
            OFS_ENSET, OFS_ENCLR: reg_rdata = {30'd0, int_en};
            OFS_EVDONE:           reg_rdata = {31'd0, ev_done};
            OFS_EVERR:            reg_rdata = {31'd0, ev_err};
            default:              reg_rdata = '0;
        endcase
    end

    assign irq = (ev_done & int_en[EN_DONE_BIT]) | (ev_err & int_en[EN_ERR_BIT]);

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

endmodule

// File: rtl/cjc_sequencer.sv
module cjc_sequencer
    import cjc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LAT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              task_start,
    input  logic              task_stop,
    input  logic [LAT_W-1:0]  latency,
    input  logic [ADDR_W-1:0] data_ptr,
    input  logic              mover_done,
    output logic              busy,
    output logic              mover_go,
    output logic              abort_evt,
    output logic              ptr_fault
);

    seq_state_t       state_q, state_d;
    logic [LAT_W-1:0] cnt_q, cnt_d;
    logic [LAT_W-1:0] lat_eff;
    logic             fault_d;

    assign lat_eff = (latency == '0) ? LAT_W'(1) : latency;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            cnt_q     <= '0;
            ptr_fault <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            ptr_fault <= fault_d;
        end
    end

    // next state and strobes; priority stop > start > expiry
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        mover_go  = 1'b0;
        abort_evt = 1'b0;
        fault_d   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (task_start) begin
                    state_d = SEQ_COUNT;
                    cnt_d   = lat_eff;
                end
            end
            SEQ_COUNT: begin
                if (task_stop) begin
                    state_d   = SEQ_IDLE;
                    abort_evt = 1'b1;
                end else if (task_start) begin
                    cnt_d = lat_eff;
                end else if (cnt_q <= LAT_W'(1)) begin
                    if (data_ptr == '0) begin
                        state_d = SEQ_IDLE;
                        fault_d = 1'b1;
                    end else begin
                        state_d  = SEQ_MOVE;
                        mover_go = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q - LAT_W'(1);
                end
            end
            SEQ_MOVE: begin
                if (mover_done)
                    state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q == SEQ_COUNT);
    end

endmodule

// File: rtl/cjc_mover.sv
module cjc_mover
    import cjc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BLK_W  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base_ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cph_go,
    output logic [BLK_W-1:0]  cph_key,
    output logic [BLK_W-1:0]  cph_din,
    input  logic [BLK_W-1:0]  cph_result,
    output logic              done
);

    localparam int WPB      = BLK_W / DATA_W;
    localparam int RD_WORDS = 2 * WPB;
    localparam int RSEL_W   = $clog2(RD_WORDS);
    localparam int IDX_W    = RSEL_W + 1;
    localparam int WSEL_W   = $clog2(WPB);
    localparam int BYTES    = DATA_W / 8;
    localparam int OUT_OFS  = 2 * (BLK_W / 8);

    mv_state_t         st_q, st_d;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  iss_q;
    logic              pend_q;
    logic [RSEL_W-1:0] pidx_q;
    logic [WSEL_W-1:0] widx_q;
    logic [DATA_W-1:0] key_w [WPB];
    logic [DATA_W-1:0] din_w [WPB];
    logic [DATA_W-1:0] out_w [WPB];
    logic              rd_issue;
    logic              rd_last;

    assign rd_issue = (st_q == MV_READ) && (iss_q < IDX_W'(RD_WORDS));
    assign rd_last  = pend_q && (pidx_q == RSEL_W'(RD_WORDS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= MV_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MV_IDLE:   if (go) st_d = MV_READ;
            MV_READ:   if (rd_last) st_d = MV_CIPHER;
            MV_CIPHER: st_d = MV_WRITE;
            MV_WRITE:  if (widx_q == WSEL_W'(WPB - 1)) st_d = MV_IDLE;
            default:   st_d = MV_IDLE;
        endcase
    end

    // counters and read pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            iss_q  <= '0;
            pend_q <= 1'b0;
            pidx_q <= '0;
            widx_q <= '0;
        end else begin
            if (st_q == MV_IDLE && go) begin
                base_q <= base_ptr;
                iss_q  <= '0;
            end else if (rd_issue) begin
                iss_q <= iss_q + IDX_W'(1);
            end
            pend_q <= rd_issue;
            pidx_q <= iss_q[RSEL_W-1:0];
            if (st_q == MV_CIPHER)
                widx_q <= '0;
            else if (st_q == MV_WRITE)
                widx_q <= widx_q + WSEL_W'(1);
        end
    end

    // word capture: lowest address word is most significant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WPB; w++) begin
                key_w[w] <= '0;
                din_w[w] <= '0;
                out_w[w] <= '0;
            end
        end else begin
            for (int w = 0; w < WPB; w++) begin
                if (pend_q && pidx_q == RSEL_W'(w))
                    key_w[w] <= mem_rdata;
                if (pend_q && pidx_q == RSEL_W'(w + WPB))
                    din_w[w] <= mem_rdata;
                if (st_q == MV_CIPHER)
                    out_w[w] <= cph_result[BLK_W-1-DATA_W*w -: DATA_W];
            end
        end
    end

    for (genvar g = 0; g < WPB; g++) begin : g_pack
        assign cph_key[BLK_W-1-DATA_W*g -: DATA_W] = key_w[g];
        assign cph_din[BLK_W-1-DATA_W*g -: DATA_W] = din_w[g];
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        cph_go    = 1'b0;
        done      = 1'b0;
        unique case (st_q)
            MV_IDLE: ;
            MV_READ: begin
                mem_req  = rd_issue;
                mem_addr = base_q + ADDR_W'(iss_q) * ADDR_W'(BYTES);
            end
            MV_CIPHER: cph_go = 1'b1;
            MV_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base_q + ADDR_W'(OUT_OFS) + ADDR_W'(widx_q) * ADDR_W'(BYTES);
                mem_wdata = out_w[widx_q];
                done      = (widx_q == WSEL_W'(WPB - 1));
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cipher_job_ctrl.sv
module cipher_job_ctrl
    import cjc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int BLK_W       = 128,
    parameter int LAT_W       = 16,
    parameter int LAT_DEFAULT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              task_start,
    input  logic              task_stop,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cph_go,
    output logic [BLK_W-1:0]  cph_key,
    output logic [BLK_W-1:0]  cph_din,
    input  logic [BLK_W-1:0]  cph_result,
    output logic              busy,
    output logic              ptr_fault,
    output logic              irq
);

    logic [ADDR_W-1:0] data_ptr;
    logic [LAT_W-1:0]  latency;
    logic [1:0]        int_en;
    logic              ev_done, ev_err;
    logic              mover_go, mover_done, abort_evt;

    cjc_regfile #(
        .ADDR_W(ADDR_W), .LAT_W(LAT_W), .LAT_DEFAULT(LAT_DEFAULT)
    ) u_regfile (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .set_done(mover_done), .set_err(abort_evt),
        .data_ptr(data_ptr), .latency(latency), .int_en(int_en),
        .ev_done(ev_done), .ev_err(ev_err), .irq(irq)
    );

    cjc_sequencer #(
        .ADDR_W(ADDR_W), .LAT_W(LAT_W)
    ) u_sequencer (
        .clk(clk), .rst_n(rst_n),
        .task_start(task_start), .task_stop(task_stop),
        .latency(latency), .data_ptr(data_ptr), .mover_done(mover_done),
        .busy(busy), .mover_go(mover_go), .abort_evt(abort_evt), .ptr_fault(ptr_fault)
    );

    cjc_mover #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)
    ) u_mover (
        .clk(clk), .rst_n(rst_n),
        .go(mover_go), .base_ptr(data_ptr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cph_go(cph_go), .cph_key(cph_key), .cph_din(cph_din), .cph_result(cph_result),
        .done(mover_done)
    );

endmodule

// File: rtl/cjc_checker.sv
module cjc_checker
    import cjc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       task_start,
    input logic       task_stop,
    input logic       busy,
    input logic       ev_done,
    input logic       ev_err,
    input logic [1:0] int_en,
    input logic       irq,
    input logic       mem_req,
    input logic       ptr_fault,
    input logic       reg_we,
    input logic [7:0] reg_addr,
    input logic [0:0] wbit,
    input logic       mover_done
);

    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(task_start));

    a_r2_stop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && task_stop) |=> (!busy && ev_err));

    a_r3_stop_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && task_stop && !ev_err && !(reg_we && reg_addr == OFS_EVERR)) |=> !ev_err);

    a_r5_no_access_in_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_req);

    a_r5_done_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        mover_done |=> ev_done);

    a_r6_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_fault |-> (!mem_req && !busy));

    a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ev_done || ev_err));

    a_r8_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && (reg_addr == OFS_ENSET || reg_addr == OFS_ENCLR)) |=> $stable(int_en));

    a_r9_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_EVDONE && !wbit[0] && !mover_done) |=> !ev_done);

endmodule

bind cipher_job_ctrl cjc_checker u_cjc_checker (
    .clk(clk), .rst_n(rst_n),
    .task_start(task_start), .task_stop(task_stop),
    .busy(busy), .ev_done(ev_done), .ev_err(ev_err), .int_en(int_en), .irq(irq),
    .mem_req(mem_req), .ptr_fault(ptr_fault),
    .reg_we(reg_we), .reg_addr(reg_addr), .wbit(reg_wdata[0:0]),
    .mover_done(mover_done)
);

// File: tb/test_cipher_job_ctrl.sv
`timescale 1ns/1ps
module test_cipher_job_ctrl;
    import cjc_pkg::*;

    localparam int LAT_DEF = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         task_start = 1'b0, task_stop = 1'b0;
    logic         reg_we = 1'b0;
    logic [7:0]   reg_addr = 8'h00;
    logic [31:0]  reg_wdata = 32'd0;
    logic [31:0]  reg_rdata;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr, mem_wdata;
    logic [31:0]  mem_rdata = 32'd0;
    logic         cph_go;
    logic [127:0] cph_key, cph_din, cph_result;
    logic         busy, ptr_fault, irq;

    always #2.5 clk = ~clk;

    cipher_job_ctrl #(.LAT_DEFAULT(LAT_DEF)) i_cipher_job_ctrl (
        .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cph_go(cph_go), .cph_key(cph_key), .cph_din(cph_din),
        .cph_result(cph_result), .busy(busy), .ptr_fault(ptr_fault), .irq(irq)
    );

    // stub cipher: swap halves of the input and mix in the key
    assign cph_result = {cph_din[63:0], cph_din[127:64]} ^ cph_key;

    logic [31:0] mem [0:255];
    always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];

    typedef struct packed { logic [31:0] a; logic [31:0] d; } wr_t;
    wr_t exp_q[$];

    int n_chk = 0, n_bad = 0, mem_acc = 0, fault_cnt = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (ptr_fault) fault_cnt++;
            if (mem_req) begin
                mem_acc++;
                if (mem_we) begin
                    if (exp_q.size() == 0) begin
                        check("R5 unexpected write addr", mem_addr, 32'hFFFF_FFFF);
                    end else begin
                        wr_t e;
                        e = exp_q.pop_front();
                        check("R5 write addr", mem_addr, e.a);
                        check("R5 write data", mem_wdata, e.d);
                    end
                end
            end
        end
    end

    // driver: loads a record and queues the expected write-back
    task automatic load_job(input logic [31:0] p, input logic [127:0] key, input logic [127:0] din);
        logic [127:0] res;
        res = {din[63:0], din[127:64]} ^ key;
        for (int i = 0; i < 4; i++) begin
            mem[(p >> 2) + i]     = key[127-32*i -: 32];
            mem[(p >> 2) + 4 + i] = din[127-32*i -: 32];
            exp_q.push_back('{a: p + 32 + 4*i, d: res[127-32*i -: 32]});
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #0.1; d = reg_rdata;
    endtask

    task automatic pulse_start();
        @(negedge clk); task_start = 1; @(negedge clk); task_start = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); task_stop = 1; @(negedge clk); task_stop = 0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] v;
        v = 0;
        for (int i = 0; i < 200 && v == 0; i++) begin
            @(negedge clk); reg_rd(OFS_EVDONE, v);
        end
        check(tag, v, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n, acc0, f0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11 reset state
        check("R11 busy", {31'd0, busy}, 0);
        check("R11 irq", {31'd0, irq}, 0);
        reg_rd(OFS_LAT, v);   check("R11 latency default", v, LAT_DEF);
        reg_rd(OFS_PTR, v);   check("R11 pointer", v, 0);
        reg_rd(OFS_ENSET, v); check("R11 enables", v, 0);

        // R10 override, R1 countdown, R5 first pattern
        reg_wr(OFS_LAT, 5);
        reg_rd(OFS_LAT, v); check("R10 latency write", v, 5);
        reg_wr(OFS_PTR, 32'h100);
        load_job(32'h100, 128'h000102030405060708090A0B0C0D0E0F, 128'h00112233445566778899AABBCCDDEEFF);
        pulse_start();
        count_busy(n); check("R1 busy length", n, 5);
        wait_done("R5 done event");
        check("R5 all writes seen", exp_q.size(), 0);
        check("R7 irq masked", {31'd0, irq}, 0);

        // R8 enables, R7 irq
        reg_wr(OFS_ENSET, 32'h1);
        check("R7 irq on enable", {31'd0, irq}, 1);
        reg_rd(OFS_ENCLR, v); check("R8 enable readback", v, 1);
        reg_wr(OFS_ENCLR, 32'h1);
        check("R8 irq after clear", {31'd0, irq}, 0);
        reg_wr(OFS_ENSET, 32'h3);
        reg_rd(OFS_ENSET, v); check("R8 both enables", v, 3);
        check("R7 irq again", {31'd0, irq}, 1);

        // R9 clear event by writing zero
        reg_wr(OFS_EVDONE, 0);
        check("R9 irq drops", {31'd0, irq}, 0);
        reg_rd(OFS_EVDONE, v); check("R9 event cleared", v, 0);

        // R3 stop while idle
        pulse_stop();
        check("R3 busy", {31'd0, busy}, 0);
        reg_rd(OFS_EVERR, v); check("R3 err event", v, 0);
        check("R3 irq", {31'd0, irq}, 0);

        // R2 stop while busy
        acc0 = mem_acc;
        pulse_start();
        @(negedge clk);
        pulse_stop();
        check("R2 busy cleared", {31'd0, busy}, 0);
        reg_rd(OFS_EVERR, v); check("R2 err event", v, 1);
        check("R2 irq", {31'd0, irq}, 1);
        repeat (15) @(negedge clk);
        check("R2 no memory access", mem_acc, acc0);
        reg_rd(OFS_EVDONE, v); check("R2 no done", v, 0);
        reg_wr(OFS_EVERR, 0);

        // R4 restart while busy, second pattern
        reg_wr(OFS_LAT, 6);
        load_job(32'h100, 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F, 128'h0123456789ABCDEFFEDCBA9876543210);
        pulse_start();
        repeat (2) @(negedge clk);
        pulse_start();
        count_busy(n); check("R4 restarted length", n, 6);
        wait_done("R4 done after restart");
        check("R5 restart writes", exp_q.size(), 0);
        reg_wr(OFS_EVDONE, 0);

        // R6 zero pointer
        reg_wr(OFS_PTR, 0);
        acc0 = mem_acc; f0 = fault_cnt;
        pulse_start();
        repeat (20) @(negedge clk);
        check("R6 fault pulse", fault_cnt - f0, 1);
        check("R6 no access", mem_acc, acc0);
        reg_rd(OFS_EVDONE, v); check("R6 no done", v, 0);

        // R10 restore default and zero latency
        reg_wr(OFS_LATDEF, 0);
        reg_rd(OFS_LAT, v); check("R10 default restored", v, LAT_DEF);
        reg_wr(OFS_LAT, 0);
        reg_wr(OFS_PTR, 32'h200);
        load_job(32'h200, 128'hDEADBEEF00000000CAFEF00D11111111, 128'h8000000000000001FFFFFFFF00000000);
        pulse_start();
        count_busy(n); check("R10 zero latency as one", n, 1);

        // R12 strobes during the move are ignored
        n = 0;
        while (!mem_req && n < 50) begin n++; @(negedge clk); end
        task_start = 1; task_stop = 1;
        @(negedge clk); task_start = 0; task_stop = 0;
        check("R12 no new countdown", {31'd0, busy}, 0);
        wait_done("R12 job completes");
        reg_rd(OFS_EVERR, v); check("R12 no err event", v, 0);
        check("R12 writes", exp_q.size(), 0);

        // R11 reset during countdown
        reg_wr(OFS_LAT, 10);
        acc0 = mem_acc;
        pulse_start();
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check("R11 busy after reset", {31'd0, busy}, 0);
        reg_rd(OFS_LAT, v); check("R11 latency after reset", v, LAT_DEF);
        reg_rd(OFS_EVDONE, v); check("R11 event after reset", v, 0);
        repeat (20) @(negedge clk);
        check("R11 countdown cancelled", mem_acc, acc0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule